// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single byte requests from a host into complete bus cycles on an 8-bit asynchronous NAND flash interface. A cycle is one of four kinds: a command byte, an address byte, a data write or a data read. Each cycle has three phases whose lengths are set separately. In the setup phase the qualifier line is already valid but no strobe is active. In the strobe phase the write or read strobe is low. In the hold phase the strobe has gone high again but the qualifier and the driven data are still held. The command qualifier (CLE) marks a command byte and the address qualifier (ALE) marks an address byte. Both put the byte on the same data pins.

Each phase length is a register field that holds the wanted number of clocks minus one. A new timing value written while a cycle runs is stored and takes effect from the next cycle. The block also holds an active-low chip enable that the host sets and clears. It reports the device's ready/busy line after a two-flop synchroniser.

The host port is valid/ready. The host raises `req_valid` with `req_op` and `req_wdata` and holds them unchanged until it sees `req_ready`. `req_ready` is a one-clock pulse in the last clock of the hold phase, and that clock completes the handshake. For a read, `rd_data` is valid from that clock on. A request that is still valid in the clock after the handshake is taken as a new request. The port gives back-pressure for the whole length of a cycle.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_dq_oe` and `req_ready` are low, and the timing is at its maximum: a 4-clock setup (8 clocks when `WIDE_SETUP`=1), an 8-clock strobe and an 8-clock hold.
- R2: The setup phase lasts `cfg_setup`+1 clocks. During it the qualifier (and the data for writes) is driven and both strobes are high.
- R3: The strobe phase lasts `cfg_strobe`+1 clocks. Only one of `nand_we_n` and `nand_re_n` is ever low.
- R4: The hold phase lasts `cfg_hold`+1 clocks. `req_ready` is high for exactly one clock, the last clock of the hold phase.
- R5: With `req_op`=0 (command), `nand_cle`=1 and `nand_ale`=0 for the whole cycle. With `req_op`=1 (address), `nand_ale`=1 and `nand_cle`=0. In both cases `nand_we_n` is the strobe and `req_wdata` is driven on `nand_dq_out` with `nand_dq_oe`=1.
- R6: With `req_op`=2 (data write), both qualifiers are low, `nand_we_n` is the strobe, and the byte is driven with `nand_dq_oe`=1.
- R7: With `req_op`=3 (data read), `nand_re_n` is the strobe, `nand_we_n` stays high, `nand_dq_oe`=0, and `rd_data` holds the `nand_dq_in` value sampled in the last strobe clock.
- R8: A timing write (`cfg_we`) made during a cycle does not change that cycle. The next cycle uses the new values.
- R9: A `ce_we` pulse with `ce_off`=1 drives `nand_ce_n` high, and with `ce_off`=0 drives it low, from the next clock on.
- R10: `ready_status` follows `nand_rb` (1 = ready, 0 = busy) two clocks after a change.
- R11: With no request pending, no strobe or qualifier is active and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-clock handshake at the end of the hold phase |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_wdata | input | DATA_W | Byte to drive for command, address or write |
| rd_data | output | DATA_W | Byte captured by the last read |
| cfg_we | input | 1 | Timing write strobe |
| cfg_setup | input | SETUP_W | Setup clocks minus one (SETUP_W = 2, or 3 when WIDE_SETUP=1) |
| cfg_strobe | input | PHASE_W | Strobe clocks minus one |
| cfg_hold | input | PHASE_W | Hold clocks minus one |
| ce_we | input | 1 | Chip-enable write strobe |
| ce_off | input | 1 | 1 deselects (enable high), 0 selects |
| ready_status | output | 1 | Synchronised ready/busy (1 = ready) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command qualifier |
| nand_ale | output | 1 | Address qualifier |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DATA_W | Data pins, outbound |
| nand_dq_oe | output | 1 | Output enable for the data pins |
| nand_dq_in | input | DATA_W | Data pins, inbound |
| nand_rb | input | 1 | Device ready/busy line |

## Verification
A phase counter loaded from the wrong field, or decremented wrongly, changes how many clocks the setup, strobe or hold window lasts. The bench counts those windows at the pins, so the error shows within the first cycle. A wrong phase or opcode register shows at once as a bad qualifier, a wrong strobe or a wrong drive enable, which is checked on every sampled clock of a cycle. A timing copy that updates mid-cycle shows as a wrong window length in the very cycle that was disturbed. A missing or doubled synchroniser stage shows as an off-by-one delay on `ready_status`.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } nfc_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } nfc_phase_e;
endpackage

// File: rtl/nfc_timing_regs.sv
module nfc_timing_regs #(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [SETUP_W-1:0] setup_in,
  input  logic [PHASE_W-1:0] strobe_in,
  input  logic [PHASE_W-1:0] hold_in,
  input  logic               busy,
  output logic [PHASE_W-1:0] cur_setup,
  output logic [PHASE_W-1:0] cur_strobe,
  output logic [PHASE_W-1:0] cur_hold
);
  // staged: last host write; live: copy frozen for the running cycle
  logic [SETUP_W-1:0] stg_setup, live_setup;
  logic [PHASE_W-1:0] stg_strobe, live_strobe;
  logic [PHASE_W-1:0] stg_hold, live_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_setup  <= '1;
      stg_strobe <= '1;
      stg_hold   <= '1;
    end else if (wr) begin
      stg_setup  <= setup_in;
      stg_strobe <= strobe_in;
      stg_hold   <= hold_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_setup  <= '1;
      live_strobe <= '1;
      live_hold   <= '1;
    end else if (!busy) begin
      live_setup  <= stg_setup;
      live_strobe <= stg_strobe;
      live_hold   <= stg_hold;
    end
  end

  // between cycles the staged value is the one a starting cycle uses
  always_comb begin
    cur_setup  = PHASE_W'(busy ? live_setup : stg_setup);
    cur_strobe = busy ? live_strobe : stg_strobe;
    cur_hold   = busy ? live_hold : stg_hold;
  end

  p_live_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(live_setup) && $stable(live_strobe) && $stable(live_hold)))
    else $error("timing copy changed inside a cycle");
endmodule

// File: rtl/nfc_phase_seq.sv
module nfc_phase_seq
  import nfc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [PHASE_W-1:0] len_setup,
  input  logic [PHASE_W-1:0] len_strobe,
  input  logic [PHASE_W-1:0] len_hold,
  input  logic [DATA_W-1:0]  dq_in,
  output logic               busy,
  output logic               done,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic [DATA_W-1:0]  dq_out,
  output logic               dq_oe,
  output logic [DATA_W-1:0]  rd_data
);
  nfc_phase_e         phase, nxt_phase;
  nfc_op_e            op_q, nxt_op;
  logic [PHASE_W-1:0] cnt, nxt_cnt;
  logic               accept, last_strobe;

  always_comb begin
    nxt_phase   = phase;
    nxt_op      = op_q;
    nxt_cnt     = cnt;
    accept      = 1'b0;
    last_strobe = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        accept    = 1'b1;
        nxt_phase = PH_SETUP;
        nxt_op    = nfc_op_e'(req_op);
        nxt_cnt   = len_setup;
      end
      PH_SETUP: if (cnt == '0) begin
        nxt_phase = PH_STROBE;
        nxt_cnt   = len_strobe;
      end else nxt_cnt = cnt - 1'b1;
      PH_STROBE: if (cnt == '0) begin
        last_strobe = 1'b1;
        nxt_phase   = PH_HOLD;
        nxt_cnt     = len_hold;
      end else nxt_cnt = cnt - 1'b1;
      PH_HOLD: if (cnt == '0) nxt_phase = PH_IDLE;
               else nxt_cnt = cnt - 1'b1;
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      op_q  <= OP_CMD;
      cnt   <= '0;
    end else begin
      phase <= nxt_phase;
      op_q  <= nxt_op;
      cnt   <= nxt_cnt;
    end
  end

  // pins are flopped from the next state so they switch cleanly with the phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cle   <= 1'b0;
      ale   <= 1'b0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      cle   <= (nxt_phase != PH_IDLE) && (nxt_op == OP_CMD);
      ale   <= (nxt_phase != PH_IDLE) && (nxt_op == OP_ADDR);
      we_n  <= !((nxt_phase == PH_STROBE) && (nxt_op != OP_READ));
      re_n  <= !((nxt_phase == PH_STROBE) && (nxt_op == OP_READ));
      dq_oe <= (nxt_phase != PH_IDLE) && (nxt_op != OP_READ);
      done  <= (nxt_phase == PH_HOLD) && (nxt_cnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out  <= '0;
      rd_data <= '0;
    end else begin
      if (accept) dq_out <= req_wdata;
      if (last_strobe && (op_q == OP_READ)) rd_data <= dq_in;
    end
  end

  assign busy = (phase != PH_IDLE);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)) else $error("both strobes low");
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("acknowledge longer than one clock");
  p_qual_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)) else $error("both qualifiers high");
  p_read_nodrive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe) else $error("data driven during read strobe");
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (we_n && re_n && !cle && !ale && !done))
    else $error("bus activity while idle");
endmodule

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

  p_sync_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == $past(chain[STAGES-2])) else $error("synchroniser skipped a stage");
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nfc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit WIDE_SETUP = 1'b0,
  parameter int SETUP_W    = WIDE_SETUP ? 3 : 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               cfg_we,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [PHASE_W-1:0] cfg_strobe,
  input  logic [PHASE_W-1:0] cfg_hold,
  input  logic               ce_we,
  input  logic               ce_off,
  output logic               ready_status,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [DATA_W-1:0]  nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [DATA_W-1:0]  nand_dq_in,
  input  logic               nand_rb
);
  logic               seq_busy;
  logic [PHASE_W-1:0] len_setup, len_strobe, len_hold;

  nfc_timing_regs #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .wr(cfg_we),
    .setup_in(cfg_setup), .strobe_in(cfg_strobe), .hold_in(cfg_hold),
    .busy(seq_busy),
    .cur_setup(len_setup), .cur_strobe(len_strobe), .cur_hold(len_hold)
  );

  nfc_phase_seq #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
    .len_setup(len_setup), .len_strobe(len_strobe), .len_hold(len_hold),
    .dq_in(nand_dq_in),
    .busy(seq_busy), .done(req_ready),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_out(nand_dq_out), .dq_oe(nand_dq_oe), .rd_data(rd_data)
  );

  nfc_rb_sync #(.STAGES(2)) u_rb (
    .clk(clk), .rst_n(rst_n), .async_in(nand_rb), .sync_out(ready_status)
  );

  // chip enable: high (deselected) out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nand_ce_n <= 1'b1;
    else if (ce_we) nand_ce_n <= ce_off;
  end

  p_ce_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_we |=> (nand_ce_n == $past(ce_off))) else $error("chip enable write lost");
endmodule

// File: tb/nand_cycle_gen_bench.sv
`timescale 1ns/1ps
module nand_cycle_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_setup = 2'd0;
  logic [2:0] cfg_strobe = 3'd0;
  logic [2:0] cfg_hold = 3'd0;
  logic       ce_we = 1'b0;
  logic       ce_off = 1'b0;
  logic       ready_status;
  logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out;
  logic [7:0] nand_dq_in = 8'h00;
  logic       nand_rb = 1'b1;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  nand_cycle_gen u_nand_cycle_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .ce_we(ce_we), .ce_off(ce_off), .ready_status(ready_status),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_timing(input logic [1:0] s, input logic [2:0] st, input logic [2:0] h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_setup = s; cfg_strobe = st; cfg_hold = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one cycle starting at a negedge; counts phase windows at the pins
  task automatic run_cycle(input logic [1:0] op, input logic [7:0] wb, input logic [7:0] rb,
                           input int es, input int est, input int eh, input string req,
                           input bit mid_cfg, input logic [1:0] ms, input logic [2:0] mst,
                           input logic [2:0] mh);
    int ph = 0, ns = 0, nst = 0, nh = 0, bad = 0, acks = 0;
    bit got = 0;
    bit strobe, other;
    req_valid = 1'b1; req_op = op; req_wdata = wb; nand_dq_in = rb;
    for (int k = 0; k < 64 && !got; k++) begin
      @(negedge clk);
      if (mid_cfg && k == 1) begin
        cfg_we = 1'b1; cfg_setup = ms; cfg_strobe = mst; cfg_hold = mh;
      end
      if (k == 2) cfg_we = 1'b0;
      strobe = (op == 2'd3) ? !nand_re_n : !nand_we_n;
      other  = (op == 2'd3) ? !nand_we_n : !nand_re_n;
      if (other) bad++;
      if (nand_cle != (op == 2'd0)) bad++;
      if (nand_ale != (op == 2'd1)) bad++;
      if (nand_dq_oe != (op != 2'd3)) bad++;
      if (op != 2'd3 && nand_dq_out != wb) bad++;
      if (ph == 0 && strobe) ph = 1;
      else if (ph == 1 && !strobe) ph = 2;
      else if (ph == 2 && strobe) bad++;
      if (ph == 0) ns++;
      else if (ph == 1) nst++;
      else nh++;
      if (req_ready) begin
        got = 1;
        acks++;
      end
    end
    check(ns == es, {req, " setup clocks"}, ns, es);
    check(nst == est, {req, " strobe clocks"}, nst, est);
    check(nh == eh, {req, " hold clocks to ack"}, nh, eh);
    check(bad == 0, {req, " pin pattern errors"}, bad, 0);
    check(got, {req, " acknowledge seen"}, int'(got), 1);
    if (op == 2'd3) check(rd_data == rb, "R7 read byte", rd_data, rb);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check(!req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
          "R4 ack one clock, bus idle after", int'(req_ready), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes and enable high", 0, 1);
    check(!nand_cle && !nand_ale && !nand_dq_oe && !req_ready, "R1 qualifiers low", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cycle(2'd0, 8'h70, 8'h00, 4, 8, 8, "R1 default timing", 0, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic t_timing;
    set_timing(2'd0, 3'd0, 3'd0);
    run_cycle(2'd0, 8'h90, 8'h00, 1, 1, 1, "R2 R3 R4 minimum cmd", 0, 2'd0, 3'd0, 3'd0);
    set_timing(2'd2, 3'd5, 3'd1);
    run_cycle(2'd1, 8'h3E, 8'h00, 3, 6, 2, "R5 address cycle", 0, 2'd0, 3'd0, 3'd0);
    run_cycle(2'd0, 8'hFF, 8'h00, 3, 6, 2, "R5 command cycle", 0, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic t_write;
    set_timing(2'd1, 3'd2, 3'd3);
    run_cycle(2'd2, 8'hA5, 8'h00, 2, 3, 4, "R6 data write", 0, 2'd0, 3'd0, 3'd0);
    run_cycle(2'd2, 8'h5A, 8'h00, 2, 3, 4, "R6 data write 2", 0, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic t_read;
    set_timing(2'd0, 3'd3, 3'd0);
    run_cycle(2'd3, 8'h00, 8'h3C, 1, 4, 1, "R7 data read", 0, 2'd0, 3'd0, 3'd0);
    set_timing(2'd3, 3'd7, 3'd7);
    run_cycle(2'd3, 8'h00, 8'hC3, 4, 8, 8, "R7 long read", 0, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic t_midcfg;
    set_timing(2'd3, 3'd3, 3'd3);
    run_cycle(2'd0, 8'h60, 8'h00, 4, 4, 4, "R8 cycle under write", 1, 2'd0, 3'd1, 3'd0);
    run_cycle(2'd1, 8'h12, 8'h00, 1, 2, 1, "R8 next cycle", 0, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic t_chip_enable;
    @(negedge clk);
    ce_we = 1'b1; ce_off = 1'b0;
    @(negedge clk);
    ce_we = 1'b0; ce_off = 1'b1;
    check(nand_ce_n == 1'b0, "R9 select drives low", nand_ce_n, 0);
    @(negedge clk);
    check(nand_ce_n == 1'b0, "R9 off without write ignored", nand_ce_n, 0);
    ce_we = 1'b1; ce_off = 1'b1;
    @(negedge clk);
    ce_we = 1'b0;
    check(nand_ce_n == 1'b1, "R9 deselect drives high", nand_ce_n, 1);
  endtask

  task automatic t_ready;
    @(negedge clk);
    check(ready_status == 1'b1, "R10 ready reported", ready_status, 1);
    nand_rb = 1'b0;
    @(negedge clk);
    check(ready_status == 1'b1, "R10 one clock still old", ready_status, 1);
    @(negedge clk);
    check(ready_status == 1'b0, "R10 busy after two clocks", ready_status, 0);
    nand_rb = 1'b1;
    repeat (2) @(negedge clk);
    check(ready_status == 1'b1, "R10 ready again", ready_status, 1);
  endtask

  task automatic t_idle;
    int act = 0;
    req_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!nand_we_n || !nand_re_n || nand_cle || nand_ale || req_ready) act++;
    end
    check(act == 0, "R11 no activity without request", act, 0);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_write();
    t_read();
    t_midcfg();
    t_chip_enable();
    t_ready();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    misses++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule